// File: doc/BRIEF.md
# UART Receive Status Flags

This block sits between a UART receiver's deserializer and the CPU bus. When the deserializer reports a completed frame, the block latches the received byte into a holding register. It also records the conditions found in that frame as sticky flags: a parity failure, a missing stop bit, a break, and an overrun of an unread byte. The CPU sees these flags together with the transmitter's two empty levels and the live CTS pin as one 8-bit read-only status byte.

A read of the receive data register drains the byte and clears most flags. The overrun flag is the exception: it clears only on a data read that happens while no unread byte is pending. Software must therefore read the data register a second time to acknowledge an overrun.

Top module: `uart_rx_status`

## Requirements
- R1: During reset the status byte reads 0 in bits 7 to 3 and 1 in bits 2 and 1, and bit 0 equals the `cts` input. The received-byte output reads 0.
- R2: A cycle with `frm_valid` high sets status bit 7 (data available) from the next cycle, and `rx_data` shows that frame's byte from the next cycle.
- R3: A cycle with `rdr_rd` high and `frm_valid` low clears status bit 7 from the next cycle.
- R4: A frame with `frm_par_fail` high sets status bit 6 (parity error). The flag stays set across later frames until a data read. The deserializer raises `frm_par_fail` only when parity checking is enabled.
- R5: A frame whose `frm_stop` is 0 sets status bit 4 (framing error). The flag stays set until a data read.
- R6: Status bit 3 (break) sets only for a frame whose data byte is all zero, whose `frm_pbit_zero` is 1 and whose `frm_stop` is 0. A frame with any one of these three conditions missing leaves bit 3 unchanged. A break frame also sets bit 4.
- R7: A frame that arrives while status bit 7 is 1 sets status bit 5 (overrun). Its byte replaces the held byte on `rx_data`, and bit 7 stays 1.
- R8: A data read made while bit 7 is 1 leaves bit 5 unchanged. A data read made while bit 7 is 0, with no frame in the same cycle, clears bit 5.
- R9: A data read with no frame in the same cycle clears bits 6, 4 and 3 from the next cycle.
- R10: When a frame and a data read occur in the same cycle, the frame wins. Bit 7 ends at 1. Bits 6, 4 and 3 take exactly that frame's conditions. Bit 5 sets if bit 7 was 1 before the cycle.
- R11: Outside reset, status bits 2, 1 and 0 follow the `thr_empty`, `tx_empty` and `cts` inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: a frame has completed |
| frm_data | input | 8 | Data byte of the completed frame |
| frm_par_fail | input | 1 | Parity check failed (only raised when parity checking is enabled) |
| frm_stop | input | 1 | Sampled value of the stop bit |
| frm_pbit_zero | input | 1 | Parity or multiprocessor bit position sampled 0 (or is absent) |
| rdr_rd | input | 1 | One-cycle strobe: CPU reads the receive data register |
| thr_empty | input | 1 | Transmit holding register empty level |
| tx_empty | input | 1 | Transmitter fully idle level |
| cts | input | 1 | CTS pin level |
| rx_data | output | 8 | Held received byte |
| status | output | 8 | Status byte {avail, parity, overrun, framing, break, thr_empty, tx_empty, cts} |

## Verification
The in-RTL assertions check on every cycle the following:
- a frame always leaves data available and its byte on the output;
- a plain read drains the available flag;
- a frame that meets a pending byte raises overrun;
- a read while a byte is pending never drops overrun;
- break is never set without framing error.

Several behaviours are shown only by the bench scenarios: the two-read sequence needed to clear an overrun, the exact three-way condition for break, the same-cycle frame-and-read priority, and the forced reset values of the transmitter bits. These are covered by directed cases, together with a seeded random run that is compared every cycle against a reference model in the bench.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

    // Per-frame conditions reported by the deserializer
    typedef struct packed {
        logic par_fail;
        logic stop;
        logic pbit_zero;
    } frm_cond_t;

    // Sticky receive flags
    typedef struct packed {
        logic rda;
        logic pe;
        logic ovr;
        logic fe;
        logic brk;
    } rx_flags_t;

    // Error flags raised by one frame
    typedef struct packed {
        logic pe;
        logic fe;
        logic brk;
    } err_hit_t;

    localparam int STAT_W = 8;

    function automatic err_hit_t frame_hits(frm_cond_t c, logic data_zero);
        err_hit_t h;
        h.pe  = c.par_fail;
        h.fe  = ~c.stop;
        h.brk = data_zero & c.pbit_zero & ~c.stop;
        return h;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(rx_flags_t f, logic thr,
                                                      logic txe, logic cts_l);
        return {f.rda, f.pe, f.ovr, f.fe, f.brk, thr, txe, cts_l};
    endfunction

endpackage

// File: rtl/uart_rxs_hold.sv
module uart_rxs_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              rd,
    output logic [DATA_W-1:0] data_q,
    output logic              rda_q,
    output logic              ovr_q
);
    logic [DATA_W-1:0] data_n;
    logic              rda_n;
    logic              ovr_n;

    always_comb begin
        data_n = data_q;
        rda_n  = rda_q;
        ovr_n  = ovr_q;
        if (frm_valid) begin
            data_n = frm_data;
            rda_n  = 1'b1;
            if (rda_q) ovr_n = 1'b1;
        end else if (rd) begin
            rda_n = 1'b0;
            if (!rda_q) ovr_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rda_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            data_q <= data_n;
            rda_q  <= rda_n;
            ovr_q  <= ovr_n;
        end
    end

    // R2
    rda_set_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> rda_q);
    // R2
    data_load_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> data_q == $past(frm_data));
    // R3
    rda_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !frm_valid) |=> !rda_q);
    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && rda_q) |=> ovr_q);
    // R8
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && rda_q && ovr_q) |=> ovr_q);

endmodule

// File: rtl/uart_rxs_err.sv
module uart_rxs_err
    import uart_rxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frm_valid,
    input  frm_cond_t cond,
    input  logic      data_zero,
    input  logic      rd,
    output err_hit_t  err_q
);
    err_hit_t hit;
    err_hit_t base;
    err_hit_t err_n;

    always_comb begin
        hit  = frame_hits(cond, data_zero);
        base = rd ? err_hit_t'('0) : err_q;
        if (frm_valid) err_n = base | hit;
        else           err_n = base;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= err_n;
    end

    // R6
    brk_needs_fe_chk: assert property (@(posedge clk) disable iff (rst)
        err_q.brk |-> err_q.fe);
    // R9
    rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !frm_valid) |=> (err_q == '0));

endmodule

// File: rtl/uart_rxs_pack.sv
module uart_rxs_pack
    import uart_rxs_pkg::*;
(
    input  logic              rst,
    input  rx_flags_t         flags,
    input  logic              thr_empty,
    input  logic              tx_empty,
    input  logic              cts,
    output logic [STAT_W-1:0] status
);
    logic thr_v;
    logic txe_v;

    always_comb begin
        thr_v  = rst | thr_empty;
        txe_v  = rst | tx_empty;
        status = pack_status(flags, thr_v, txe_v, cts);
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_par_fail,
    input  logic              frm_stop,
    input  logic              frm_pbit_zero,
    input  logic              rdr_rd,
    input  logic              thr_empty,
    input  logic              tx_empty,
    input  logic              cts,
    output logic [DATA_W-1:0] rx_data,
    output logic [STAT_W-1:0] status
);
    frm_cond_t cond;
    err_hit_t  err_q;
    rx_flags_t flags;
    logic      rda_q;
    logic      ovr_q;
    logic      data_zero;

    assign cond      = '{par_fail: frm_par_fail, stop: frm_stop, pbit_zero: frm_pbit_zero};
    assign data_zero = (frm_data == '0);

    uart_rxs_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .frm_valid(frm_valid),
        .frm_data (frm_data),
        .rd       (rdr_rd),
        .data_q   (rx_data),
        .rda_q    (rda_q),
        .ovr_q    (ovr_q)
    );

    uart_rxs_err u_err (
        .clk      (clk),
        .rst      (rst),
        .frm_valid(frm_valid),
        .cond     (cond),
        .data_zero(data_zero),
        .rd       (rdr_rd),
        .err_q    (err_q)
    );

    assign flags = '{rda: rda_q, pe: err_q.pe, ovr: ovr_q, fe: err_q.fe, brk: err_q.brk};

    uart_rxs_pack u_pack (
        .rst      (rst),
        .flags    (flags),
        .thr_empty(thr_empty),
        .tx_empty (tx_empty),
        .cts      (cts),
        .status   (status)
    );

    // R10
    frame_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && rdr_rd) |=> (status[7] && status[4] == $past(!frm_stop)));

endmodule

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       frm_valid, frm_par_fail, frm_stop, frm_pbit_zero;
    logic [7:0] frm_data;
    logic       rdr_rd, thr_empty, tx_empty, cts;
    logic [7:0] rx_data, status;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state
    logic m_rda, m_pe, m_ovr, m_fe, m_brk;
    logic [7:0] m_data;

    always #4 clk = ~clk;

    uart_rx_status u_uart_rx_status (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_par_fail(frm_par_fail), .frm_stop(frm_stop), .frm_pbit_zero(frm_pbit_zero),
        .rdr_rd(rdr_rd), .thr_empty(thr_empty), .tx_empty(tx_empty), .cts(cts),
        .rx_data(rx_data), .status(status)
    );

    function automatic logic [7:0] exp_status();
        return {m_rda, m_pe, m_ovr, m_fe, m_brk, thr_empty, tx_empty, cts};
    endfunction

    function automatic logic is_brk(logic [7:0] d, logic pz, logic st);
        return (d == 8'h00) && pz && !st;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic model_update();
        if (frm_valid) begin
            logic bpe, bfe, bbk;
            bpe = rdr_rd ? 1'b0 : m_pe;
            bfe = rdr_rd ? 1'b0 : m_fe;
            bbk = rdr_rd ? 1'b0 : m_brk;
            if (m_rda) m_ovr = 1'b1;
            m_rda  = 1'b1;
            m_data = frm_data;
            m_pe   = bpe | frm_par_fail;
            m_fe   = bfe | !frm_stop;
            m_brk  = bbk | is_brk(frm_data, frm_pbit_zero, frm_stop);
        end else if (rdr_rd) begin
            if (!m_rda) m_ovr = 1'b0;
            m_rda = 1'b0; m_pe = 1'b0; m_fe = 1'b0; m_brk = 1'b0;
        end
    endtask

    // drive at negedge, clock it, compare at next negedge
    task automatic step(logic fv, logic [7:0] d, logic pf, logic st, logic pz, logic rd);
        frm_valid = fv; frm_data = d; frm_par_fail = pf; frm_stop = st;
        frm_pbit_zero = pz; rdr_rd = rd;
        @(posedge clk);
        model_update();
        @(negedge clk);
        frm_valid = 1'b0; rdr_rd = 1'b0;
    endtask

    task automatic cmp_all();
        logic [7:0] e;
        e = exp_status();
        check("R2 avail",    {7'd0, status[7]}, {7'd0, e[7]});
        check("R4 parity",   {7'd0, status[6]}, {7'd0, e[6]});
        check("R7 overrun",  {7'd0, status[5]}, {7'd0, e[5]});
        check("R5 framing",  {7'd0, status[4]}, {7'd0, e[4]});
        check("R6 break",    {7'd0, status[3]}, {7'd0, e[3]});
        check("R11 tx bits", {5'd0, status[2:0]}, {5'd0, e[2:0]});
        check("R2 data",     rx_data, m_data);
    endtask

    task automatic good(logic [7:0] d);   // clean frame
        step(1'b1, d, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask
    task automatic rd_only();
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_rda = 0; m_pe = 0; m_ovr = 0; m_fe = 0; m_brk = 0; m_data = 8'h00;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; frm_valid = 0; frm_data = 0; frm_par_fail = 0; frm_stop = 1;
        frm_pbit_zero = 0; rdr_rd = 0; thr_empty = 0; tx_empty = 0; cts = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values, transmitter bits forced high
        check("R1 reset status cts=1", status, 8'b0000_0111);
        cts = 0; #1;
        check("R1 reset status cts=0", status, 8'b0000_0110);
        check("R1 reset data", rx_data, 8'h00);
        do_reset();
        // R11 low bits follow inputs outside reset
        thr_empty = 0; tx_empty = 1; cts = 1; #1;
        check("R11 follow", {5'd0, status[2:0]}, 8'b0000_0011);
        thr_empty = 1; tx_empty = 0; cts = 0; #1;
        check("R11 follow", {5'd0, status[2:0]}, 8'b0000_0100);

        // R2 then R3
        good(8'hA5);
        check("R2 avail+data", {status[7:3], 3'b0}, 8'b1000_0000);
        check("R2 data", rx_data, 8'hA5);
        rd_only();
        check("R3 read clears avail", {status[7:3], 3'b0}, 8'h00);

        // R7 overrun, overwrite; R8 two-read clear
        good(8'h11);
        good(8'h22);
        check("R7 overrun set", {status[7:3], 3'b0}, 8'b1010_0000);
        check("R7 byte replaced", rx_data, 8'h22);
        rd_only();
        check("R8 first read keeps overrun", {status[7:3], 3'b0}, 8'b0010_0000);
        rd_only();
        check("R8 second read clears overrun", {status[7:3], 3'b0}, 8'h00);

        // R4 parity sticky across a clean frame, R9 read clears
        step(1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0);
        rd_only();
        step(1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0);
        good(8'h01);
        check("R4 parity sticky", {status[7:3], 3'b0}, 8'b1110_0000);
        rd_only(); rd_only();
        check("R9 read clears errors", {status[7:3], 3'b0}, 8'h00);

        // R6 break cases
        step(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 break frame sets break and framing", {status[7:3], 3'b0}, 8'b1001_1000);
        rd_only();
        step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 pbit one: no break", {status[7:3], 3'b0}, 8'b1001_0000);
        rd_only();
        step(1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R6 stop one: no break", {status[7:3], 3'b0}, 8'b1000_0000);
        rd_only();
        step(1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R5 R6 data nonzero: framing only", {status[7:3], 3'b0}, 8'b1001_0000);

        // R10 same-cycle frame and read, avail was 1, old framing error present
        step(1'b1, 8'h77, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R10 frame wins", {status[7:3], 3'b0}, 8'b1110_0000);
        check("R10 data", rx_data, 8'h77);
        rd_only(); rd_only();

        // random phase against model
        for (int i = 0; i < 4000; i++) begin
            logic fv, rd, pf, st, pz;
            logic [7:0] d;
            fv = ($urandom % 100) < 35;
            rd = ($urandom % 100) < 35;
            pf = ($urandom % 4) == 0;
            st = ($urandom % 4) != 0;
            pz = ($urandom % 2) == 0;
            d  = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
            thr_empty = 1'($urandom); tx_empty = 1'($urandom); cts = 1'($urandom);
            step(fv, d, pf, st, pz, rd);
            cmp_all();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule